// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Detector and Entry Sequencer

This block is the front end for the non-maskable interrupt of an 8-bit processor core. On every active clock edge it samples the active-low interrupt pin. A request is recorded whenever a high sample is followed directly by a low sample, at any cycle and not only at instruction ends. A pin that stays low never produces a second request. After a request is recorded, the block waits for the core's instruction-complete strobe. It then runs a fixed seven-cycle entry: two internal cycles, three stack writes, and two vector reads. The cycle after the last read carries the new program counter and a one-cycle done strobe.

The core supplies the return address, the status byte and the stack pointer. These are captured in the cycle the entry is accepted. The memory side is a plain one-cycle request model. Each write or read request is taken in the cycle it is raised, so there is no ready signal and no back-pressure. Vector read data must be valid in the same cycle as the read request. A falling edge that arrives while an entry is running is recorded again. It starts a further entry at the next instruction boundary.

Top module: `nmi_entry_unit`

## Requirements
- R1: Reset clears the pending request and disarms the detector. A pin that is low from reset produces no request until it has been sampled high and then low. While reset is asserted or the block is idle, no stack write, vector read or done strobe is raised.
- R2: A sample of 1 on `nmi_n` followed by a sample of 0 on the next clock edge raises `nmi_pending` in the cycle after that edge. This holds in every cycle, including during an instruction and during an entry.
- R3: A pin that stays low after a recorded edge produces no further request, however many instructions complete.
- R4: A pending request starts an entry only in a cycle where `insn_done` is 1 and no entry is running. The first entry cycle follows that cycle.
- R5: Entry cycles 3, 4 and 5 each raise `stk_wr_valid`. The writes go to addresses 0x01:SP, 0x01:SP-1 and 0x01:SP-2, with 8-bit wrap inside page 0x01. The data written is PC[15:8], then PC[7:0], then the status byte, all captured when the entry was accepted.
- R6: Entry cycles 6 and 7 raise `vec_rd_valid`, first at address 0xFFFA (low byte) and then at 0xFFFB (high byte). The entry lasts exactly 7 cycles.
- R7: In the cycle after entry cycle 7, `pc_load_valid` is 1 for exactly one cycle. In that cycle `pc_load_value` is {data read at 0xFFFB, data read at 0xFFFA}.
- R8: A falling edge recorded during an entry sets `nmi_pending` again. A second entry then follows at the next `insn_done`, and the request is not lost.
- R9: `nmi_pending` is 0 during the first entry cycle, unless a new falling edge was sampled on the accepting clock edge.
- R10: A high level that spans just one sampling edge re-arms the detector. A high pulse that lies wholly between two sampling edges is ignored.
- R11: `stk_wr_valid` and `vec_rd_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is the sampling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Active-low non-maskable interrupt pin |
| insn_done | input | 1 | Current instruction completes in this cycle |
| pc_in | input | 16 | Return address to push |
| status_in | input | 8 | Status byte to push |
| sp_in | input | 8 | Current stack pointer (offset in page 0x01) |
| vec_rd_data | input | 8 | Vector read data, valid in the same cycle as the request |
| nmi_pending | output | 1 | A recorded request is waiting |
| stk_wr_valid | output | 1 | Stack write request, one cycle |
| stk_wr_addr | output | 16 | Stack write address |
| stk_wr_data | output | 8 | Stack write data |
| vec_rd_valid | output | 1 | Vector read request, one cycle |
| vec_rd_addr | output | 16 | Vector read address |
| pc_load_valid | output | 1 | One-cycle strobe: new PC is available |
| pc_load_value | output | 16 | PC loaded from the vector |

## Verification
The hardest case to reach from the ports is a falling edge that lands inside a running entry. It must be recorded while the earlier request has just been cleared, and then wait for a later instruction boundary. The stimulus gets there by releasing the pin for exactly one sampling edge in the middle of the pushes. The bench then withholds `insn_done` until the first entry has ended. Two timing-sensitive pulse cases are also driven between clock edges. In one, the pin goes high and low again inside a single cycle, so no edge ever sees the high level. In the other, the pin is high for exactly one sampled edge.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  // Entry sequence: two internal cycles, three pushes, two vector reads.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP1,
    ST_GAP2,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_SR,
    ST_VEC_LO,
    ST_VEC_HI
  } entry_state_t;

  localparam int unsigned ENTRY_CYCLES = 7;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n_i,
  input  logic take_i,
  output logic pending_o
);
  // armed_q: the previous sample read high. Cleared by reset, so a pin
  // that is already low needs a high sample before it can fire.
  logic armed_q;
  logic pend_q;
  logic fall;

  assign fall = armed_q & ~nmi_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      armed_q <= nmi_n_i;
      // A fresh edge wins over the clear at entry start.
      pend_q  <= fall | (pend_q & ~take_i);
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  input  logic              insn_done_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] vec_data_i,
  output logic              take_o,
  output logic              stk_valid_o,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              load_valid_o,
  output logic [ADDR_W-1:0] load_value_o
);
  // The stack address is the page byte followed by the pointer byte.
  localparam int unsigned PAGE_W = ADDR_W - DATA_W;

  entry_state_t      state_q;
  logic [DATA_W-1:0] sp_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] vlo_q;
  logic [ADDR_W-1:0] load_q;
  logic              done_q;

  assign take_o = (state_q == ST_IDLE) & pending_i & insn_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
      vlo_q   <= '0;
      load_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_VEC_HI);
      unique case (state_q)
        ST_IDLE: if (take_o) begin
          sp_q    <= sp_i;
          pc_q    <= pc_i;
          sr_q    <= status_i;
          state_q <= ST_GAP1;
        end
        ST_GAP1:    state_q <= ST_GAP2;
        ST_GAP2:    state_q <= ST_PUSH_HI;
        ST_PUSH_HI: begin sp_q <= sp_q - 1'b1; state_q <= ST_PUSH_LO; end
        ST_PUSH_LO: begin sp_q <= sp_q - 1'b1; state_q <= ST_PUSH_SR; end
        ST_PUSH_SR: begin sp_q <= sp_q - 1'b1; state_q <= ST_VEC_LO;  end
        ST_VEC_LO:  begin vlo_q <= vec_data_i; state_q <= ST_VEC_HI; end
        ST_VEC_HI:  begin load_q <= {vec_data_i, vlo_q}; state_q <= ST_IDLE; end
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stk_valid_o = 1'b0;
    stk_data_o  = '0;
    unique case (state_q)
      ST_PUSH_HI: begin stk_valid_o = 1'b1; stk_data_o = pc_q[ADDR_W-1 -: DATA_W]; end
      ST_PUSH_LO: begin stk_valid_o = 1'b1; stk_data_o = pc_q[DATA_W-1:0];        end
      ST_PUSH_SR: begin stk_valid_o = 1'b1; stk_data_o = sr_q;                    end
      default: ;
    endcase
  end

  assign stk_addr_o   = {STACK_PAGE[PAGE_W-1:0], sp_q};
  assign vec_valid_o  = (state_q == ST_VEC_LO) | (state_q == ST_VEC_HI);
  assign vec_addr_o   = (state_q == ST_VEC_HI) ? VEC_ADDR + 16'd1 : VEC_ADDR;
  assign load_valid_o = done_q;
  assign load_value_o = load_q;
endmodule

// File: rtl/nmi_entry_unit.sv
module nmi_entry_unit #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              insn_done,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] vec_rd_data,
  output logic              nmi_pending,
  output logic              stk_wr_valid,
  output logic [ADDR_W-1:0] stk_wr_addr,
  output logic [DATA_W-1:0] stk_wr_data,
  output logic              vec_rd_valid,
  output logic [ADDR_W-1:0] vec_rd_addr,
  output logic              pc_load_valid,
  output logic [ADDR_W-1:0] pc_load_value
);
  logic take;

  nmi_edge_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_n_i   (nmi_n),
    .take_i    (take),
    .pending_o (nmi_pending)
  );

  nmi_entry_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pending_i    (nmi_pending),
    .insn_done_i  (insn_done),
    .pc_i         (pc_in),
    .status_i     (status_in),
    .sp_i         (sp_in),
    .vec_data_i   (vec_rd_data),
    .take_o       (take),
    .stk_valid_o  (stk_wr_valid),
    .stk_addr_o   (stk_wr_addr),
    .stk_data_o   (stk_wr_data),
    .vec_valid_o  (vec_rd_valid),
    .vec_addr_o   (vec_rd_addr),
    .load_valid_o (pc_load_valid),
    .load_value_o (pc_load_value)
  );
endmodule

// File: rtl/nmi_entry_checker.sv
module nmi_entry_checker #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [15:0] VEC_ADDR = 16'hFFFA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_n,
  input logic              insn_done,
  input logic              nmi_pending,
  input logic              stk_wr_valid,
  input logic [ADDR_W-1:0] stk_wr_addr,
  input logic              vec_rd_valid,
  input logic [ADDR_W-1:0] vec_rd_addr,
  input logic              pc_load_valid
);
  // R11: one bus request per cycle at most
  assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_wr_valid && vec_rd_valid));

  // R2 / R3: a new request needs a high sample then a low sample
  assert_edge_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pending) |-> (!$past(nmi_n) && $past(nmi_n, 2)));

  // R4: pushes begin three cycles after an accepted boundary
  assert_wait_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_wr_valid) |-> ($past(insn_done, 3) && $past(nmi_pending, 3)));

  // R5: consecutive pushes go to descending addresses
  assert_push_descend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_wr_valid) |=> (stk_wr_valid && stk_wr_addr[7:0] == $past(stk_wr_addr[7:0]) - 8'd1));

  // R6: low vector byte read is followed by the high byte
  assert_vector_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_valid && vec_rd_addr == VEC_ADDR) |=>
      (vec_rd_valid && vec_rd_addr == VEC_ADDR + 16'd1));

  // R7: done strobe follows the high vector read and lasts one cycle
  assert_done_after_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |-> ($past(vec_rd_valid) && $past(vec_rd_addr) == VEC_ADDR + 16'd1));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |=> !pc_load_valid);
endmodule

bind nmi_entry_unit nmi_entry_checker #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nmi_n         (nmi_n),
  .insn_done     (insn_done),
  .nmi_pending   (nmi_pending),
  .stk_wr_valid  (stk_wr_valid),
  .stk_wr_addr   (stk_wr_addr),
  .vec_rd_valid  (vec_rd_valid),
  .vec_rd_addr   (vec_rd_addr),
  .pc_load_valid (pc_load_valid)
);

// File: tb/test_nmi_entry_unit.sv
`timescale 1ns/1ps
module test_nmi_entry_unit;
  localparam logic [7:0] VLO = 8'h34;
  localparam logic [7:0] VHI = 8'hC2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b0;
  logic insn_done = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  status_in = 8'h00;
  logic [7:0]  sp_in = 8'hFF;
  logic [7:0]  vec_rd_data;
  logic        nmi_pending, stk_wr_valid, vec_rd_valid, pc_load_valid;
  logic [15:0] stk_wr_addr, vec_rd_addr, pc_load_value;
  logic [7:0]  stk_wr_data;

  int checks = 0;
  int failures = 0;
  int entries = 0;

  always #4 clk = ~clk;

  assign vec_rd_data = vec_rd_addr[0] ? VHI : VLO;

  nmi_entry_unit i_nmi_entry_unit (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .insn_done(insn_done),
    .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in), .vec_rd_data(vec_rd_data),
    .nmi_pending(nmi_pending), .stk_wr_valid(stk_wr_valid), .stk_wr_addr(stk_wr_addr),
    .stk_wr_data(stk_wr_data), .vec_rd_valid(vec_rd_valid), .vec_rd_addr(vec_rd_addr),
    .pc_load_valid(pc_load_valid), .pc_load_value(pc_load_value)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a step counter 0 (idle) or 1..7 (entry cycle).
  bit        m_last_high, m_pend, m_done;
  int        m_step;
  bit [7:0]  m_sp, m_st;
  bit [15:0] m_pc, m_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last_high = 0; m_pend = 0; m_done = 0; m_step = 0; m_load = 0;
    end else begin
      bit fell, go;
      fell = m_last_high && (nmi_n == 1'b0);
      go   = (m_step == 0) && m_pend && insn_done;
      m_done = (m_step == 7);
      if (m_step == 7) m_load = {VHI, VLO};
      if (go) begin
        m_sp = sp_in; m_pc = pc_in; m_st = status_in; m_step = 1;
      end else if (m_step == 7) m_step = 0;
      else if (m_step > 0) m_step++;
      m_pend = fell || (m_pend && !go);
      m_last_high = nmi_n;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit        e_stk, e_vec;
      bit [15:0] e_addr;
      bit [7:0]  e_data;
      e_stk = (m_step >= 3 && m_step <= 5);
      e_vec = (m_step >= 6);
      check(nmi_pending == m_pend, "R2 pending", nmi_pending, m_pend);
      check(stk_wr_valid == e_stk, "R5 stk_wr_valid", stk_wr_valid, e_stk);
      if (e_stk) begin
        e_addr = {8'h01, 8'(m_sp - 8'(m_step - 3))};
        e_data = (m_step == 3) ? m_pc[15:8] : (m_step == 4) ? m_pc[7:0] : m_st;
        check(stk_wr_addr == e_addr, "R5 stk_wr_addr", stk_wr_addr, e_addr);
        check(stk_wr_data == e_data, "R5 stk_wr_data", stk_wr_data, e_data);
      end
      check(vec_rd_valid == e_vec, "R6 vec_rd_valid", vec_rd_valid, e_vec);
      if (e_vec)
        check(vec_rd_addr == 16'hFFFA + 16'(m_step - 6), "R6 vec_rd_addr",
              vec_rd_addr, 16'hFFFA + 16'(m_step - 6));
      check(pc_load_valid == m_done, "R7 pc_load_valid", pc_load_valid, m_done);
      if (m_done) check(pc_load_value == m_load, "R7 pc_load_value", pc_load_value, m_load);
      check(!(stk_wr_valid && vec_rd_valid), "R11 exclusive", {stk_wr_valid, vec_rd_valid}, 0);
      if (pc_load_valid) entries++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic boundary(input int gap);
    insn_done = 1'b1; cyc(1); insn_done = 1'b0; cyc(gap);
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    // R1: pin low through reset and after it
    cyc(3);
    check(nmi_pending == 1'b0 && stk_wr_valid == 1'b0 && vec_rd_valid == 1'b0,
          "R1 reset outputs", {nmi_pending, stk_wr_valid, vec_rd_valid}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) boundary(2);
    check(nmi_pending == 1'b0, "R1 low from reset no request", nmi_pending, 0);
    check(entries == 0, "R1 no entry from reset-low pin", entries, 0);

    // R2 / R4: edge recorded, entry waits for boundary
    nmi_n = 1'b1; cyc(3); nmi_n = 1'b0; cyc(1);
    check(nmi_pending == 1'b1, "R2 edge recorded", nmi_pending, 1);
    cyc(6);
    check(entries == 0 && stk_wr_valid == 1'b0, "R4 waits for insn_done", entries, 0);
    pc_in = 16'hA1B2; status_in = 8'h5C; sp_in = 8'hFD;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    check(nmi_pending == 1'b0, "R9 pending cleared in first entry cycle", nmi_pending, 0);
    cyc(8);
    check(entries == 1, "R6 R7 one entry completed", entries, 1);

    // R3: held low across many boundaries
    for (int k = 0; k < 12; k++) boundary(3);
    check(entries == 1 && nmi_pending == 1'b0, "R3 held low no retrigger", entries, 1);

    // R10: one-sample high gap re-arms; stack wraps inside page
    pc_in = 16'h0F80; status_in = 8'hE3; sp_in = 8'h01;
    nmi_n = 1'b1; cyc(1); nmi_n = 1'b0; cyc(1);
    check(nmi_pending == 1'b1, "R10 one-sample high gap re-arms", nmi_pending, 1);
    boundary(10);
    check(entries == 2, "R10 entry after one-sample gap", entries, 2);

    // R10: high pulse between two sampling edges ignored
    for (int k = 0; k < 3; k++) begin
      #1 nmi_n = 1'b1; #1 nmi_n = 1'b0;
      cyc(1);
    end
    check(nmi_pending == 1'b0, "R10 unsampled pulse ignored", nmi_pending, 0);
    for (int k = 0; k < 3; k++) boundary(2);
    check(entries == 2, "R10 no entry from unsampled pulse", entries, 2);

    // R8: new edge during entry queues a second one
    pc_in = 16'h4321; status_in = 8'h01; sp_in = 8'h80;
    nmi_n = 1'b1; cyc(1); nmi_n = 1'b0; cyc(1);
    base = entries;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    cyc(3);
    nmi_n = 1'b1; cyc(1); nmi_n = 1'b0; cyc(1);
    check(nmi_pending == 1'b1, "R8 edge during entry recorded", nmi_pending, 1);
    cyc(6);
    check(entries == base + 1 && nmi_pending == 1'b1, "R8 request kept after entry",
          entries, base + 1);
    pc_in = 16'h9876; status_in = 8'hAA; sp_in = 8'h7D;
    boundary(10);
    check(entries == base + 2, "R8 queued entry serviced", entries, base + 2);

    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule